// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a supervision timer that counts down from a value loaded by software. When the count hits zero while the timer is armed, that is a timeout. Software must restart the count (a kick) often enough to keep timeouts from happening. A small word-wide register port configures the timer. Through it, software sets the reload value, arms or disarms the counter, picks one of two responses, kicks the counter, acknowledges the interrupt and reads back the live count.

In the direct response, the first timeout sends a one-cycle reset request to the system. In the two-stage response, the first timeout raises an interrupt and reloads the counter at once. If the interrupt is still pending at the next timeout, the reset request fires. Either way, a reset request disarms the timer, so it stays idle until software arms it again.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset, the control word (address 0), the reload value (address 1), the count (address 2) and the status word (address 3) all read as zero, and `irq_o` and `rst_req_o` are low.
- R2: The control word holds the arm bit at bit 0 and the response select at bit 1 (0 = direct, 1 = two-stage). A write to address 1 sets the reload value and reads back unchanged. Changing the arm bit from 0 to 1 loads the count from the reload value in the next cycle. After that, the count drops by one per cycle, as read at address 2.
- R3: An armed cycle with a count of zero is a timeout. On the next cycle the count is back at the reload value.
- R4: In the direct response, a timeout drives `rst_req_o` high for exactly one cycle, starting the cycle after the zero count. The same edge clears the arm bit, and `irq_o` stays low.
- R5: In the two-stage response, a timeout with no interrupt pending sets the pending flag (status bit 0) and raises `irq_o`. It does not request a reset, and counting continues from the reload value.
- R6: In the two-stage response, a timeout while the interrupt is pending produces the one-cycle reset request. It also clears the arm bit and the pending flag. The response select keeps its value.
- R7: A write of any value to address 3 clears the pending flag. A clear that lands in the same cycle as a timeout counts as having arrived in time: no reset is requested, and the flag is raised again for a new first stage.
- R8: While armed, a write to address 2 reloads the count and leaves the pending flag alone. A kick in a cycle whose count is zero prevents that timeout. A kick while disarmed has no effect on the count.
- R9: While disarmed, the count holds its value and `irq_o` stays low, even if the pending flag is set. Arming again with the flag still set brings `irq_o` back at once, and the next timeout requests a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register write address |
| wr_data_i | input | CNT_W | Register write data |
| rd_addr_i | input | 2 | Register read address (combinational read) |
| rd_data_o | output | CNT_W | Register read data |
| irq_o | output | 1 | First-stage timeout interrupt, masked while disarmed |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
The bench builds the block with a 16-bit counter and reload values of five, so that each timeout period lasts a few cycles. This brings double timeouts, kicks at the zero count, clears that coincide with a timeout, and disarm–rearm with a pending flag all within a short run. The checker module tracks the counter step, the reload after zero and the cause of each reset request cycle by cycle for any counter width.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

    localparam int unsigned ADDR_W        = 2;
    localparam int unsigned CTRL_EN_BIT   = 0;
    localparam int unsigned CTRL_MODE_BIT = 1;
    localparam int unsigned STAT_PEND_BIT = 0;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL   = 2'd0,
        A_PRESET = 2'd1,
        A_COUNT  = 2'd2,
        A_STATUS = 2'd3
    } wdt_addr_e;

    typedef enum logic {
        M_DIRECT    = 1'b0,
        M_TWO_STAGE = 1'b1
    } wdt_mode_e;

endpackage

// File: rtl/wdt_cfg.sv
module wdt_cfg
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic              disarm_i,
    output logic              en_o,
    output wdt_mode_e         mode_o,
    output logic [CNT_W-1:0]  preset_o,
    output logic              arm_o,
    output logic              kick_o,
    output logic              clr_o
);

    typedef struct packed {
        logic             en;
        wdt_mode_e        mode;
        logic [CNT_W-1:0] preset;
    } cfg_t;

    cfg_t cfg_d, cfg_q;
    logic hit_ctrl, hit_preset, hit_count, hit_status;

    // Address decode of the write port into per-register strobes
    always_comb begin
        hit_ctrl   = wr_en_i && (wr_addr_i == A_CTRL);
        hit_preset = wr_en_i && (wr_addr_i == A_PRESET);
        hit_count  = wr_en_i && (wr_addr_i == A_COUNT);
        hit_status = wr_en_i && (wr_addr_i == A_STATUS);
    end

    // Next-state of the configuration; a reset request wins over a write
    always_comb begin
        cfg_d = cfg_q;
        arm_o = 1'b0;
        if (hit_ctrl) begin
            cfg_d.en   = wr_data_i[CTRL_EN_BIT];
            cfg_d.mode = wdt_mode_e'(wr_data_i[CTRL_MODE_BIT]);
            arm_o      = wr_data_i[CTRL_EN_BIT] && !cfg_q.en;
        end
        if (hit_preset) begin
            cfg_d.preset = wr_data_i;
        end
        if (disarm_i) begin
            cfg_d.en = 1'b0;
            arm_o    = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign en_o     = cfg_q.en;
    assign mode_o   = cfg_q.mode;
    assign preset_o = cfg_q.preset;
    assign kick_o   = hit_count;
    assign clr_o    = hit_status;

endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic             arm_i,
    input  logic             kick_i,
    input  logic [CNT_W-1:0] preset_i,
    output logic [CNT_W-1:0] count_o,
    output logic             expire_o
);

    localparam logic [CNT_W-1:0] STEP = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } cnt_t;

    cnt_t cnt_d, cnt_q;
    logic reload;

    // Reload on arm or armed kick; an armed kick also masks a zero count
    always_comb begin
        cnt_d    = cnt_q;
        reload   = arm_i || (en_i && kick_i);
        expire_o = en_i && !kick_i && (cnt_q.count == '0);
        if (reload || expire_o) begin
            cnt_d.count = preset_i;
        end else if (en_i) begin
            cnt_d.count = cnt_q.count - STEP;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign count_o = cnt_q.count;

endmodule

// File: rtl/wdt_stage.sv
module wdt_stage
    import wdt_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      expire_i,
    input  wdt_mode_e mode_i,
    input  logic      clr_i,
    output logic      pend_o,
    output logic      rst_req_o,
    output logic      disarm_o
);

    typedef struct packed {
        logic pend;
        logic rst_req;
    } stage_t;

    stage_t stg_d, stg_q;
    logic   fire;
    logic   raise;

    // Decide between first-stage interrupt and final reset request
    always_comb begin
        stg_d = stg_q;
        fire  = expire_i &&
                ((mode_i == M_DIRECT) || (stg_q.pend && !clr_i));
        raise = expire_i && (mode_i == M_TWO_STAGE) && !fire;
        stg_d.rst_req = fire;
        if (fire) begin
            stg_d.pend = 1'b0;
        end else if (raise) begin
            stg_d.pend = 1'b1;
        end else if (clr_i) begin
            stg_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            stg_q <= '0;
        end else begin
            stg_q <= stg_d;
        end
    end

    assign pend_o    = stg_q.pend;
    assign rst_req_o = stg_q.rst_req;
    assign disarm_o  = fire;

endmodule

// File: rtl/wdog_two_stage.sv
module wdog_two_stage
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [CNT_W-1:0]  wr_data_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [CNT_W-1:0]  rd_data_o,
    output logic              irq_o,
    output logic              rst_req_o
);

    logic             arm_en;
    wdt_mode_e        mode_sel;
    logic [CNT_W-1:0] preset_val;
    logic             arm_stb;
    logic             kick_stb;
    logic             clr_stb;
    logic             disarm;
    logic [CNT_W-1:0] cnt_val;
    logic             expire;
    logic             pend;

    wdt_cfg #(.CNT_W(CNT_W)) u_cfg (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .disarm_i  (disarm),
        .en_o      (arm_en),
        .mode_o    (mode_sel),
        .preset_o  (preset_val),
        .arm_o     (arm_stb),
        .kick_o    (kick_stb),
        .clr_o     (clr_stb)
    );

    wdt_count #(.CNT_W(CNT_W)) u_count (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .en_i     (arm_en),
        .arm_i    (arm_stb),
        .kick_i   (kick_stb),
        .preset_i (preset_val),
        .count_o  (cnt_val),
        .expire_o (expire)
    );

    wdt_stage u_stage (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .expire_i  (expire),
        .mode_i    (mode_sel),
        .clr_i     (clr_stb),
        .pend_o    (pend),
        .rst_req_o (rst_req_o),
        .disarm_o  (disarm)
    );

    // Read multiplexer over the four register words
    always_comb begin
        rd_data_o = '0;
        case (wdt_addr_e'(rd_addr_i))
            A_CTRL: begin
                rd_data_o[CTRL_EN_BIT]   = arm_en;
                rd_data_o[CTRL_MODE_BIT] = mode_sel;
            end
            A_PRESET: rd_data_o = preset_val;
            A_COUNT:  rd_data_o = cnt_val;
            A_STATUS: rd_data_o[STAT_PEND_BIT] = pend;
            default:  rd_data_o = '0;
        endcase
    end

    assign irq_o = pend && arm_en;

endmodule

// File: rtl/wdog_checker.sv
module wdog_checker #(
    parameter int unsigned CNT_W = 32
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             arm_en,
    input logic [CNT_W-1:0] cnt_val,
    input logic [CNT_W-1:0] preset_val,
    input logic             kick_stb,
    input logic             irq_o,
    input logic             rst_req_o
);

    assert_reset_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |=> !rst_req_o);

    assert_reset_disarms_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |-> !arm_en);

    assert_reset_cause_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_req_o |-> ($past(arm_en) && ($past(cnt_val) == '0)));

    assert_irq_masked_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !arm_en |-> !irq_o);

    assert_count_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!arm_en && !$past(arm_en)) |-> $stable(cnt_val));

    assert_count_step_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arm_en && $past(arm_en) && ($past(cnt_val) != '0) && !$past(kick_stb))
        |-> (cnt_val == $past(cnt_val) - CNT_W'(1)));

    assert_zero_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(arm_en) && ($past(cnt_val) == '0)) |-> (cnt_val == $past(preset_val)));

    assert_irq_cause_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(irq_o) |-> (($past(cnt_val) == '0) || !$past(arm_en)));

endmodule

bind wdog_two_stage wdog_checker #(.CNT_W(CNT_W)) u_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .arm_en     (arm_en),
    .cnt_val    (cnt_val),
    .preset_val (preset_val),
    .kick_stb   (kick_stb),
    .irq_o      (irq_o),
    .rst_req_o  (rst_req_o)
);

// File: tb/test_wdog_two_stage.sv
module test_wdog_two_stage;

    localparam int unsigned DW = 16;
    localparam int K_RD  = 0;
    localparam int K_IRQ = 1;
    localparam int K_RST = 2;

    typedef struct {
        int          cyc;
        int          kind;
        logic [1:0]  addr;
        logic [DW-1:0] val;
        string       tag;
    } item_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [1:0]    rd_addr = '0;
    logic [DW-1:0] rd_data;
    logic          irq;
    logic          rst_req;

    int    cyc = 0;
    int    checks = 0;
    int    fails = 0;
    item_t sb[$];

    wdog_two_stage #(.CNT_W(DW)) i_wdog_two_stage (
        .clk_i     (clk),
        .rst_ni    (rst_n),
        .wr_en_i   (wr_en),
        .wr_addr_i (wr_addr),
        .wr_data_i (wr_data),
        .rd_addr_i (rd_addr),
        .rd_data_o (rd_data),
        .irq_o     (irq),
        .rst_req_o (rst_req)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic expect_at(int c, int kind, logic [1:0] a, logic [DW-1:0] v, string tag);
        sb.push_back('{c, kind, a, v, tag});
    endtask

    task automatic put(logic [1:0] a, logic [DW-1:0] d, output int w);
        w = cyc;
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic go_to(int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic compare(item_t it);
        logic [DW-1:0] act;
        if (it.kind == K_RD) begin
            rd_addr = it.addr;
            #1;
            act = rd_data;
        end else if (it.kind == K_IRQ) begin
            act = DW'(irq);
        end else begin
            act = DW'(rst_req);
        end
        checks++;
        if (act !== it.val) begin
            fails++;
            $display("FAIL %s cycle %0d kind %0d addr %0d: actual %0h expected %0h",
                     it.tag, it.cyc, it.kind, it.addr, act, it.val);
        end
    endtask

    // Monitor: pops every item due in the current cycle
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                for (int i = 0; i < sb.size(); ) begin
                    if (sb[i].cyc == cyc) begin
                        automatic item_t it = sb[i];
                        sb.delete(i);
                        compare(it);
                    end else begin
                        i++;
                    end
                end
            end
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > 20000) begin
                fails++;
                $display("FAIL watchdog: run did not finish, actual cycle %0d expected below 20000", cyc);
                $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
                $finish;
            end
        end
    end

    initial begin
        int w;
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        expect_at(cyc + 1, K_RD, 2'd0, '0, "R1");
        expect_at(cyc + 1, K_RD, 2'd1, '0, "R1");
        expect_at(cyc + 1, K_RD, 2'd2, '0, "R1");
        expect_at(cyc + 1, K_RD, 2'd3, '0, "R1");
        expect_at(cyc + 2, K_IRQ, 2'd0, '0, "R1");
        expect_at(cyc + 2, K_RST, 2'd0, '0, "R1");
        go_to(cyc + 3);

        // R2, R3, R4: direct response with reload value 5
        put(2'd1, 16'd5, w);
        expect_at(w + 1, K_RD, 2'd1, 16'd5, "R2");
        put(2'd0, 16'h1, w);
        expect_at(w + 1, K_RD, 2'd2, 16'd5, "R2");
        expect_at(w + 3, K_RD, 2'd2, 16'd3, "R2");
        expect_at(w + 6, K_RD, 2'd2, 16'd0, "R3");
        expect_at(w + 7, K_RD, 2'd2, 16'd5, "R3");
        expect_at(w + 7, K_IRQ, 2'd0, '0, "R4");
        expect_at(w + 7, K_RST, 2'd0, 16'd1, "R4");
        expect_at(w + 8, K_RST, 2'd0, '0, "R4");
        expect_at(w + 8, K_RD, 2'd0, '0, "R4");
        expect_at(w + 10, K_RD, 2'd2, 16'd5, "R9");
        go_to(w + 11);

        // R5, R6: two-stage, interrupt never cleared
        put(2'd0, 16'h3, w);
        expect_at(w + 1, K_RD, 2'd2, 16'd5, "R2");
        expect_at(w + 7, K_IRQ, 2'd0, 16'd1, "R5");
        expect_at(w + 7, K_RST, 2'd0, '0, "R5");
        expect_at(w + 7, K_RD, 2'd2, 16'd5, "R5");
        expect_at(w + 8, K_RD, 2'd2, 16'd4, "R5");
        expect_at(w + 12, K_IRQ, 2'd0, 16'd1, "R5");
        expect_at(w + 13, K_RST, 2'd0, 16'd1, "R6");
        expect_at(w + 13, K_IRQ, 2'd0, '0, "R6");
        expect_at(w + 14, K_RST, 2'd0, '0, "R6");
        expect_at(w + 14, K_RD, 2'd0, 16'h2, "R6");
        expect_at(w + 14, K_RD, 2'd3, '0, "R6");
        go_to(w + 15);

        // R7, R9: clear in time, then disarm and rearm with pending flag
        put(2'd0, 16'h3, w);
        expect_at(w + 7, K_IRQ, 2'd0, 16'd1, "R5");
        go_to(w + 9);
        put(2'd3, 16'hFFFF, v);
        expect_at(w + 10, K_IRQ, 2'd0, '0, "R7");
        expect_at(w + 10, K_RD, 2'd3, '0, "R7");
        expect_at(w + 13, K_IRQ, 2'd0, 16'd1, "R7");
        expect_at(w + 13, K_RST, 2'd0, '0, "R7");
        expect_at(w + 13, K_RD, 2'd2, 16'd5, "R7");
        go_to(w + 14);
        put(2'd0, 16'h2, v);
        expect_at(w + 15, K_IRQ, 2'd0, '0, "R9");
        expect_at(w + 15, K_RST, 2'd0, '0, "R9");
        expect_at(w + 15, K_RD, 2'd2, 16'd3, "R9");
        expect_at(w + 18, K_RD, 2'd2, 16'd3, "R9");
        expect_at(w + 18, K_RD, 2'd3, 16'd1, "R9");
        go_to(w + 19);
        put(2'd0, 16'h3, v);
        expect_at(v + 1, K_IRQ, 2'd0, 16'd1, "R9");
        expect_at(v + 1, K_RD, 2'd2, 16'd5, "R9");
        expect_at(v + 7, K_RST, 2'd0, 16'd1, "R9");
        expect_at(v + 8, K_RD, 2'd0, 16'h2, "R6");
        expect_at(v + 8, K_IRQ, 2'd0, '0, "R6");
        go_to(v + 9);

        // R8: kicks keep the pending flag and stop a zero-count timeout
        put(2'd0, 16'h3, w);
        expect_at(w + 7, K_IRQ, 2'd0, 16'd1, "R5");
        go_to(w + 9);
        put(2'd2, 16'h0, v);
        expect_at(w + 10, K_RD, 2'd2, 16'd5, "R8");
        expect_at(w + 10, K_IRQ, 2'd0, 16'd1, "R8");
        expect_at(w + 15, K_RD, 2'd2, 16'd0, "R8");
        go_to(w + 15);
        put(2'd2, 16'h0, v);
        expect_at(w + 16, K_RD, 2'd2, 16'd5, "R8");
        expect_at(w + 16, K_RST, 2'd0, '0, "R8");
        expect_at(w + 16, K_IRQ, 2'd0, 16'd1, "R8");
        go_to(w + 17);
        put(2'd0, 16'h2, v);
        go_to(w + 19);
        put(2'd2, 16'h0, v);
        expect_at(w + 20, K_RD, 2'd2, 16'd3, "R8");
        expect_at(w + 20, K_IRQ, 2'd0, '0, "R9");
        go_to(w + 21);
        put(2'd3, 16'h0, v);
        expect_at(w + 22, K_RD, 2'd3, '0, "R7");
        go_to(w + 23);

        // R7: clear in the same cycle as the second timeout
        put(2'd0, 16'h3, w);
        expect_at(w + 7, K_IRQ, 2'd0, 16'd1, "R5");
        go_to(w + 12);
        put(2'd3, 16'h0, v);
        expect_at(w + 13, K_RST, 2'd0, '0, "R7");
        expect_at(w + 13, K_IRQ, 2'd0, 16'd1, "R7");
        expect_at(w + 13, K_RD, 2'd2, 16'd5, "R7");
        expect_at(w + 14, K_RST, 2'd0, '0, "R7");
        expect_at(w + 14, K_RD, 2'd0, 16'h3, "R7");
        go_to(w + 15);
        put(2'd0, 16'h0, v);
        go_to(cyc + 4);

        foreach (sb[i]) begin
            fails++;
            $display("FAIL %s cycle %0d: actual never sampled expected %0h", sb[i].tag, sb[i].cyc, sb[i].val);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule